// File: doc/BRIEF.md
# Cache Command Register Controller

This block is the command front end of a two-way set-associative cache. Software writes a command code into it. The block decodes the code and then either sets the cache-enable flag or walks every set once, one set per clock, to clear lock bits (unlock all) or to drop valid bits and point each set's replacement indicator at way 0 (invalidate all). While a walk is in progress the block reports busy. A command written while busy is dropped and leaves a sticky error bit. Command codes outside the defined set do nothing.

The per-line valid and lock bits and the per-set LRU bit live in this block. The fill path updates them through a single write port. A lookup port exposes the state of one set, so the state can be read back after a reset. The valid, lock and LRU bits have no reset. Reset clears only the enable flag, the busy state and the error bit. The recommended bring-up is unlock all, then invalidate all, then enable. After it every line is invalid and every LRU bit selects way 0.

A parameter selects one of two variants. The instruction-side variant takes a 3-bit command and the data-side variant takes a 4-bit command. Both variants behave the same way.

Top module: `cache_cmd_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, enable, busy and err all read 0.
- R2: Reset does not change any valid bit, lock bit or LRU bit; the lookup port returns the values from before the reset.
- R3: The enable code (3'b001 on the instruction variant, 4'b0010 on the data variant), accepted while idle, sets enable at the next clock. It does not raise busy. Enable stays set until reset.
- R4: The unlock-all code (3'b101 / 4'b1010), accepted while idle, raises busy on the next clock. Busy stays high for exactly NUM_SETS cycles. Set k has both of its lock bits cleared at the (k+1)-th clock after acceptance.
- R5: The invalidate-all code (3'b110 / 4'b1100) uses the same timing as R4. In each set it clears the valid bit of every unlocked line, leaves locked lines valid, and forces the LRU bit to 0.
- R6: A command written while busy is ignored, and err is set at the next clock. Err stays set until reset.
- R7: Any code other than the three above has no effect on enable, busy, err or the stored state.
- R8: A fill while idle sets the valid bit of the chosen line, copies fill_lock into its lock bit, and sets the set's LRU bit to the other way. A fill while busy is ignored.
- R9: The instruction and data variants produce the same port behaviour for the same command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | CMD_W (3 or 4) | Command code |
| fill_en | input | 1 | Line fill/update strobe |
| fill_set | input | SET_W | Set written by a fill |
| fill_way | input | 1 | Way written by a fill |
| fill_lock | input | 1 | Lock value stored by a fill |
| look_set | input | SET_W | Set shown on the lookup outputs |
| busy | output | 1 | A sweep is running |
| err | output | 1 | Sticky: a command arrived while busy |
| enable | output | 1 | Cache enable flag |
| look_valid | output | 2 | Valid bits of look_set, bit index = way |
| look_lock | output | 2 | Lock bits of look_set, bit index = way |
| look_lru | output | 1 | LRU bit of look_set (way to replace next) |

## Verification
A sweep pointer that skips or repeats shows up in two ways. Busy ends one cycle early or late. A set that was not touched keeps a stale lock or valid bit, and the lookup port shows it as soon as that set is selected after the sweep. A wrong decode or a wrong enable path shows on enable, busy or err at the first clock after the write. The bench scans the lookup port over all sets on every cycle, so a corrupted set is seen within NUM_SETS cycles. Reset retention is checked by comparing all sets before and after a reset.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_UNLOCK = 2'd1,
    OP_INVAL  = 2'd2,
    OP_ENABLE = 2'd3
  } ccr_op_e;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
  parameter bit DATA_VARIANT = 1'b0,
  localparam int CMD_W = DATA_VARIANT ? 4 : 3
) (
  input  logic [CMD_W-1:0] code,
  output ccr_pkg::ccr_op_e op
);
  import ccr_pkg::*;

  generate
    if (DATA_VARIANT) begin : g_data
      always_comb begin
        case (code)
          4'b1010: op = OP_UNLOCK;
          4'b1100: op = OP_INVAL;
          4'b0010: op = OP_ENABLE;
          default: op = OP_NONE;
        endcase
      end
    end else begin : g_instr
      always_comb begin
        case (code)
          3'b101:  op = OP_UNLOCK;
          3'b110:  op = OP_INVAL;
          3'b001:  op = OP_ENABLE;
          default: op = OP_NONE;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ccr_sweep.sv
module ccr_sweep #(
  parameter int NUM_SETS = 64,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  ccr_pkg::ccr_op_e  cmd_op,
  output logic              busy,
  output logic              err,
  output logic              enable,
  output logic              sweep_en,
  output ccr_pkg::ccr_op_e  sweep_op,
  output logic [SET_W-1:0]  sweep_set
);
  import ccr_pkg::*;

  localparam logic [SET_W-1:0] LAST = SET_W'(NUM_SETS - 1);

  typedef enum logic {ST_IDLE, ST_SWEEP} st_e;

  st_e              state_q, state_d;
  logic [SET_W-1:0] ptr_q, ptr_d;
  ccr_op_e          op_q, op_d;
  logic             err_q, err_d;
  logic             en_q, en_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    op_d    = op_q;
    err_d   = err_q;
    en_d    = en_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_we) begin
          if (cmd_op == OP_UNLOCK || cmd_op == OP_INVAL) begin
            state_d = ST_SWEEP;
            ptr_d   = '0;
            op_d    = cmd_op;
          end else if (cmd_op == OP_ENABLE) begin
            en_d = 1'b1;
          end
        end
      end
      ST_SWEEP: begin
        if (cmd_we) err_d = 1'b1;
        if (ptr_q == LAST) begin
          state_d = ST_IDLE;
          ptr_d   = '0;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      op_q    <= OP_NONE;
      err_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      op_q    <= op_d;
      err_q   <= err_d;
      en_q    <= en_d;
    end
  end

  assign busy      = (state_q == ST_SWEEP);
  assign err       = err_q;
  assign enable    = en_q;
  assign sweep_en  = busy;
  assign sweep_op  = op_q;
  assign sweep_set = ptr_q;

  // R4: the sweep ends right after the last set
  assert_sweep_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr_q == LAST) |=> !busy);

  // R4: the pointer advances by exactly one set per cycle
  assert_ptr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr_q != LAST) |=> (busy && ptr_q == $past(ptr_q) + 1'b1));

  // R6: a write during a sweep flags an error
  assert_busy_write_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> err);

  // R6: the error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R3: the enable command takes effect at the next clock and holds
  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && cmd_op == OP_ENABLE) |=> enable);

  assert_enable_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> enable);
endmodule

// File: rtl/ccr_tag_state.sv
module ccr_tag_state #(
  parameter int NUM_SETS = 64,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAYS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [SET_W-1:0]  fill_set,
  input  logic              fill_way,
  input  logic              fill_lock,
  input  logic              sweep_en,
  input  ccr_pkg::ccr_op_e  sweep_op,
  input  logic [SET_W-1:0]  sweep_set,
  input  logic [SET_W-1:0]  look_set,
  output logic [WAYS-1:0]   look_valid,
  output logic [WAYS-1:0]   look_lock,
  output logic              look_lru
);
  import ccr_pkg::*;

  logic [NUM_SETS-1:0][WAYS-1:0] valid_q, valid_d;
  logic [NUM_SETS-1:0][WAYS-1:0] lock_q, lock_d;
  logic [NUM_SETS-1:0]           lru_q, lru_d;
  logic                          upd;

  generate
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic hit_fill, hit_inval, hit_unlock;
      assign hit_fill   = fill_en && (fill_set == SET_W'(s));
      assign hit_inval  = sweep_en && (sweep_set == SET_W'(s)) && (sweep_op == OP_INVAL);
      assign hit_unlock = sweep_en && (sweep_set == SET_W'(s)) && (sweep_op == OP_UNLOCK);
      for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic fill_here;
        assign fill_here = hit_fill && (fill_way == 1'(w));
        assign valid_d[s][w] = fill_here ? 1'b1 :
                               (hit_inval && !lock_q[s][w]) ? 1'b0 : valid_q[s][w];
        assign lock_d[s][w]  = fill_here ? fill_lock :
                               hit_unlock ? 1'b0 : lock_q[s][w];
      end
      assign lru_d[s] = hit_fill ? ~fill_way : (hit_inval ? 1'b0 : lru_q[s]);
    end
  endgenerate

  assign upd = fill_en || sweep_en;

  // state has no reset on purpose: it survives a reset for inspection
  always_ff @(posedge clk) begin
    if (upd) begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
      lru_q   <= lru_d;
    end
  end

  assign look_valid = valid_q[look_set];
  assign look_lock  = lock_q[look_set];
  assign look_lru   = lru_q[look_set];

  // R8: fill and sweep never compete for the write port
  assert_fill_sweep_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && sweep_en));

  // R5: an invalidate of the looked-up set leaves its LRU at way 0
  assert_inval_lru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && sweep_op == OP_INVAL && sweep_set == look_set)
      |=> (look_set != $past(look_set) || !look_lru));
endmodule

// File: rtl/cache_cmd_ctrl.sv
module cache_cmd_ctrl #(
  parameter bit DATA_VARIANT = 1'b0,
  parameter int NUM_SETS = 64,
  localparam int CMD_W = DATA_VARIANT ? 4 : 3,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_way,
  input  logic             fill_lock,
  input  logic [SET_W-1:0] look_set,
  output logic             busy,
  output logic             err,
  output logic             enable,
  output logic [1:0]       look_valid,
  output logic [1:0]       look_lock,
  output logic             look_lru
);
  import ccr_pkg::*;

  ccr_op_e          cmd_op;
  ccr_op_e          sweep_op;
  logic             sweep_en;
  logic [SET_W-1:0] sweep_set;
  logic             fill_ok;

  ccr_decode #(.DATA_VARIANT(DATA_VARIANT)) u_decode (
    .code (cmd_code),
    .op   (cmd_op)
  );

  ccr_sweep #(.NUM_SETS(NUM_SETS)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .err       (err),
    .enable    (enable),
    .sweep_en  (sweep_en),
    .sweep_op  (sweep_op),
    .sweep_set (sweep_set)
  );

  assign fill_ok = fill_en && !busy;

  ccr_tag_state #(.NUM_SETS(NUM_SETS)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_ok),
    .fill_set   (fill_set),
    .fill_way   (fill_way),
    .fill_lock  (fill_lock),
    .sweep_en   (sweep_en),
    .sweep_op   (sweep_op),
    .sweep_set  (sweep_set),
    .look_set   (look_set),
    .look_valid (look_valid),
    .look_lock  (look_lock),
    .look_lru   (look_lru)
  );
endmodule

// File: tb/cache_cmd_ctrl_test.sv
module cache_cmd_ctrl_test;
  localparam int PERIOD = 10;
  localparam int S = 8;
  localparam int SW = $clog2(S);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  int   kind = 0;
  logic fe = 1'b0;
  logic [SW-1:0] fs = '0;
  logic fw = 1'b0;
  logic fl = 1'b0;
  logic [SW-1:0] ls = '0;
  logic [2:0] code_i;
  logic [3:0] code_d;

  logic busy_i, err_i, en_i, lru_i, busy_d, err_d, en_d, lru_d;
  logic [1:0] val_i, lck_i, val_d, lck_d;

  int checks = 0;
  int errors = 0;
  bit known = 1'b0;
  bit done = 1'b0;

  // reference model
  bit m_en, m_busy, m_err;
  int m_ptr, m_op;
  bit mv[S][2];
  bit ml[S][2];
  bit mlru[S];

  always #(PERIOD/2) clk = ~clk;

  always_comb begin
    case (kind)
      1: begin code_i = 3'b101; code_d = 4'b1010; end
      2: begin code_i = 3'b110; code_d = 4'b1100; end
      3: begin code_i = 3'b001; code_d = 4'b0010; end
      4: begin code_i = 3'b011; code_d = 4'b0110; end
      5: begin code_i = 3'b111; code_d = 4'b0001; end
      default: begin code_i = 3'b000; code_d = 4'b0000; end
    endcase
  end

  cache_cmd_ctrl #(.DATA_VARIANT(1'b0), .NUM_SETS(S)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(we), .cmd_code(code_i),
    .fill_en(fe), .fill_set(fs), .fill_way(fw), .fill_lock(fl), .look_set(ls),
    .busy(busy_i), .err(err_i), .enable(en_i),
    .look_valid(val_i), .look_lock(lck_i), .look_lru(lru_i));

  cache_cmd_ctrl #(.DATA_VARIANT(1'b1), .NUM_SETS(S)) uut_d (
    .clk(clk), .rst_n(rst_n), .cmd_we(we), .cmd_code(code_d),
    .fill_en(fe), .fill_set(fs), .fill_way(fw), .fill_lock(fl), .look_set(ls),
    .busy(busy_d), .err(err_d), .enable(en_d),
    .look_valid(val_d), .look_lock(lck_d), .look_lru(lru_d));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_err = 0; m_ptr = 0;
    end else if (m_busy) begin
      for (int w = 0; w < 2; w++) begin
        if (m_op == 1) ml[m_ptr][w] = 0;
        if (m_op == 2 && !ml[m_ptr][w]) mv[m_ptr][w] = 0;
      end
      if (m_op == 2) mlru[m_ptr] = 0;
      if (we) m_err = 1;
      if (m_ptr == S-1) begin m_busy = 0; m_ptr = 0; end
      else m_ptr = m_ptr + 1;
    end else begin
      if (fe) begin
        mv[fs][fw] = 1; ml[fs][fw] = fl; mlru[fs] = ~fw;
      end
      if (we && (kind == 1 || kind == 2)) begin
        m_busy = 1; m_ptr = 0; m_op = kind;
      end else if (we && kind == 3) m_en = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(busy_i == m_busy, "R4/R5 busy", busy_i, m_busy);
    chk(err_i == m_err, "R6 err", err_i, m_err);
    chk(en_i == m_en, "R3 enable", en_i, m_en);
    chk(busy_d == m_busy && err_d == m_err && en_d == m_en, "R9 data variant status",
        {busy_d, err_d, en_d}, {m_busy, m_err, m_en});
    if (known) begin
      chk(val_i == {mv[ls][1], mv[ls][0]}, "R5 valid", val_i, {mv[ls][1], mv[ls][0]});
      chk(lck_i == {ml[ls][1], ml[ls][0]}, "R4 lock", lck_i, {ml[ls][1], ml[ls][0]});
      chk(lru_i == mlru[ls], "R5 lru", lru_i, mlru[ls]);
      chk({val_d, lck_d, lru_d} == {val_i, lck_i, lru_i}, "R9 data variant state",
          {val_d, lck_d, lru_d}, {val_i, lck_i, lru_i});
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check_all();
    ls = SW'((int'(ls) + 1) % S);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic cmd(input int k);
    we = 1; kind = k;
    cyc();
    we = 0; kind = 0;
  endtask

  task automatic fill(input int s, input bit w, input bit l);
    fe = 1; fs = SW'(s); fw = w; fl = l;
    cyc();
    fe = 0;
  endtask

  task automatic scan(input string tag);
    for (int s = 0; s < S; s++) begin
      ls = SW'(s);
      #1;
      chk({val_i, lck_i, lru_i} == {mv[s][1], mv[s][0], ml[s][1], ml[s][0], mlru[s]},
          tag, {val_i, lck_i, lru_i}, {mv[s][1], mv[s][0], ml[s][1], ml[s][0], mlru[s]});
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(2);
    chk(!en_i && !busy_i && !err_i, "R1 reset outputs", {en_i, busy_i, err_i}, 0);
    rst_n = 1;
    cyc();
    chk(!en_i && !busy_i && !err_i, "R1 after release", {en_i, busy_i, err_i}, 0);

    // bring-up sequence
    cmd(1);
    chk(busy_i == 1, "R4 busy after unlock", busy_i, 1);
    idle(S);
    cmd(2);
    idle(S);
    known = 1;
    scan("R5 cleared after init");
    cmd(3);
    chk(en_i == 1 && busy_i == 0, "R3 enable no busy", {en_i, busy_i}, 2);

    // fills
    for (int s = 0; s < S; s++) fill(s, s[0], (s % 3) == 0);
    for (int s = 0; s < S; s += 2) fill(s, 1, 0);
    scan("R8 fills");

    // unrecognized codes
    cmd(4); cmd(5);
    idle(1);
    scan("R7 unknown code no state change");
    chk(!busy_i && !err_i, "R7 unknown code no status", {busy_i, err_i}, 0);

    // invalidate with locked lines, disturbed by writes and fills
    cmd(2);
    fill(5, 0, 1);
    cmd(3);
    chk(err_i == 1, "R6 err after busy write", err_i, 1);
    idle(S);
    scan("R5 invalidate keeps locked lines");
    scan("R8 fill during busy ignored");

    // unlock then refill
    cmd(1);
    idle(S + 1);
    scan("R4 unlock all");
    fill(1, 1, 1); fill(6, 0, 1); fill(3, 0, 0);

    // reset retains state
    rst_n = 0;
    cyc();
    rst_n = 1;
    cyc();
    scan("R2 retained over reset");
    chk(!en_i && !err_i, "R1 status cleared by reset", {en_i, err_i}, 0);

    // reset in the middle of an invalidate sweep
    cmd(2);
    idle(2);
    rst_n = 0;
    cyc();
    rst_n = 1;
    cyc();
    scan("R2 partial sweep retained");
    idle(2 * S);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule